// File: doc/BRIEF.md
# Multi-Channel Compare-Toggle PWM Timer

This block is a bank of independent 16-bit timer channels. Each channel drives one PWM pin. A channel counts up by one on each pulse of its own count strobe while it is running. Its pin starts each period at a programmable idle level. The pin flips to the opposite level once the counter reaches the duty compare value. When the counter reaches the period compare value, the next strobe wraps the counter to zero and a new period begins at the idle level. If the duty value is larger than the period value, the pin never leaves its idle level.

Software uses one synchronous write port and one registered read port. Each channel has four registers: counter, duty compare, period compare and control. A shared start register and a shared stop register hold one bit per channel. Writing a 1 to a bit of either register starts or stops only that channel. The control register has three bits: an output-enable bit, the idle level, and a shutdown-style bit. The shutdown-style bit selects what happens when output enable is cleared: the pin either drops to idle at once, or the waveform runs on until the current period ends. The intended shutdown order is to clear output enable first and then stop the counter. A stopped channel keeps its counter and its pin level.

Top module: `pwm_timer_bank`

## Requirements
- R1: After reset, every counter is 0, every duty and period register reads 16'hFFFF, every control register reads 0, all channels are stopped, and every pwm_out bit is 0.
- R2: A running channel adds 1 to its counter (modulo 2^16) on each cycle where its tick bit is 1. A write to the counter loads wr_data and takes priority over counting in the same cycle.
- R3: While the output is enabled and the duty value is not above the period value, pwm_out equals the idle level when counter < duty and the inverted idle level when counter >= duty. pwm_out reflects the register state one clock after that state.
- R4: On a tick where a running channel's counter equals its period value, the counter becomes 0. This starts a new period at the idle level, or at the inverted level when duty is 0.
- R5: When the duty value is greater than the period value, pwm_out stays at the idle level.
- R6: When output enable (control bit 0) is 0 and no shutdown drain is pending, pwm_out equals the idle level (control bit 1).
- R7: A write of D to the start address (wr_addr[AW-1]=1, wr_addr[0]=0) sets run for each channel i with D[i]=1. A write to the stop address (wr_addr[AW-1]=1, wr_addr[0]=1) clears those bits. Channels whose bit is 0 are unaffected. A read of either global address returns the run mask.
- R8: A stopped channel keeps its counter value and its pin level until a register write changes them, whatever its tick input does.
- R9: Clearing output enable with control bit 2 set drops the pin to idle on the next state update. Clearing it with bit 2 clear on a running channel keeps the waveform until the next period-end tick. If that tick falls in the same cycle as the write, the pin goes to idle at once.
- R10: The channel register address is {0, channel, field}, where field 0 is the counter, 1 is duty, 2 is period and 3 is control. A read returns the addressed value on rd_data one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | AW | Write address |
| wr_data | input | CW | Write data |
| rd_addr | input | AW | Read address |
| rd_data | output | CW | Registered read data |
| tick | input | NCH | Per-channel count strobe |
| pwm_out | output | NCH | Registered PWM pins |

## Verification
Four things are checked by assertions on every cycle: the counter step and the wrap at the period match, the frozen counter of a stopped channel, the idle level of a disabled or duty-above-period channel, and the single-bit effect of start and stop. The following can only be shown by the bench scenarios, where the reference model follows each channel through many periods: the duty/period proportion of the waveform, the non-abrupt drain that lasts until the period ends, the corner where the drain write lands on the period-end tick, and the interaction of writes with random tick patterns.

// File: rtl/pwm_bank_pkg.sv
package pwm_bank_pkg;
  typedef enum logic [1:0] {
    FLD_COUNT  = 2'd0,
    FLD_DUTY   = 2'd1,
    FLD_PERIOD = 2'd2,
    FLD_CTRL   = 2'd3
  } chan_field_e;

  localparam int CTRL_W = 3;

  // bit 0 output enable, bit 1 idle level, bit 2 abrupt shutdown
  typedef struct packed {
    logic abrupt;
    logic idle;
    logic oe;
  } chan_ctrl_t;
endpackage

// File: rtl/pwm_regdec.sv
module pwm_regdec #(
  parameter int NCH  = 8,
  parameter int CW   = 16,
  parameter int CH_W = (NCH > 1) ? $clog2(NCH) : 1,
  parameter int AW   = CH_W + 3
) (
  input  logic           wr_en,
  input  logic [AW-1:0]  wr_addr,
  input  logic [CW-1:0]  wr_data,
  output logic [NCH-1:0] we_cnt,
  output logic [NCH-1:0] we_duty,
  output logic [NCH-1:0] we_per,
  output logic [NCH-1:0] we_ctrl,
  output logic [NCH-1:0] start_set,
  output logic [NCH-1:0] stop_set
);
  import pwm_bank_pkg::*;

  logic            glob;
  logic [CH_W-1:0] chsel;
  chan_field_e     fld;

  assign glob  = wr_addr[AW-1];
  assign chsel = wr_addr[AW-2:2];
  assign fld   = chan_field_e'(wr_addr[1:0]);

  assign start_set = (wr_en && glob && !wr_addr[0]) ? wr_data[NCH-1:0] : '0;
  assign stop_set  = (wr_en && glob &&  wr_addr[0]) ? wr_data[NCH-1:0] : '0;

  for (genvar i = 0; i < NCH; i++) begin : g_dec
    logic hit;
    assign hit        = wr_en && !glob && (chsel == CH_W'(i));
    assign we_cnt[i]  = hit && (fld == FLD_COUNT);
    assign we_duty[i] = hit && (fld == FLD_DUTY);
    assign we_per[i]  = hit && (fld == FLD_PERIOD);
    assign we_ctrl[i] = hit && (fld == FLD_CTRL);
  end
endmodule

// File: rtl/pwm_chan.sv
module pwm_chan #(
  parameter int CW = 16
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    tick,
  input  logic                    start,
  input  logic                    stop,
  input  logic                    we_cnt,
  input  logic                    we_duty,
  input  logic                    we_per,
  input  logic                    we_ctrl,
  input  logic [CW-1:0]           wdata,
  output logic [CW-1:0]           cnt_o,
  output logic [CW-1:0]           duty_o,
  output logic [CW-1:0]           per_o,
  output pwm_bank_pkg::chan_ctrl_t ctrl_o,
  output logic                    run_o,
  output logic                    pwm_o
);
  import pwm_bank_pkg::*;

  logic [CW-1:0] cnt_q, duty_q, per_q;
  chan_ctrl_t    ctrl_q, ctrl_new;
  logic          run_q, drain_q, pwm_q;
  logic          period_end, phase, drive;

  assign ctrl_new   = chan_ctrl_t'(wdata[CTRL_W-1:0]);
  assign period_end = run_q && tick && (cnt_q == per_q);
  assign phase      = (cnt_q >= duty_q) && (duty_q <= per_q);
  assign drive      = ctrl_q.oe || drain_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= '0;
      duty_q  <= '1;
      per_q   <= '1;
      ctrl_q  <= '0;
      run_q   <= 1'b0;
      drain_q <= 1'b0;
      pwm_q   <= 1'b0;
    end else begin
      if (we_cnt)
        cnt_q <= wdata;
      else if (run_q && tick)
        cnt_q <= period_end ? '0 : cnt_q + 1'b1;

      if (we_duty) duty_q <= wdata;
      if (we_per)  per_q  <= wdata;
      if (we_ctrl) ctrl_q <= ctrl_new;

      if (start)     run_q <= 1'b1;
      else if (stop) run_q <= 1'b0;

      if (we_ctrl && (ctrl_new.oe || ctrl_new.abrupt))
        drain_q <= 1'b0;
      else if (we_ctrl && ctrl_q.oe && run_q && !period_end)
        drain_q <= 1'b1;
      else if (period_end)
        drain_q <= 1'b0;

      pwm_q <= drive ? (ctrl_q.idle ^ phase) : ctrl_q.idle;
    end
  end

  assign cnt_o  = cnt_q;
  assign duty_o = duty_q;
  assign per_o  = per_q;
  assign ctrl_o = ctrl_q;
  assign run_o  = run_q;
  assign pwm_o  = pwm_q;

  // R2: one step per tick while running
  assert_step_R2: assert property (@(posedge clk) disable iff (rst)
    (run_q && tick && !period_end && !we_cnt) |=> cnt_q == CW'($past(cnt_q) + 1'b1));

  // R4: wrap at the period match
  assert_wrap_R4: assert property (@(posedge clk) disable iff (rst)
    (period_end && !we_cnt) |=> cnt_q == '0);

  // R5: duty above period keeps the idle level
  assert_dutyhigh_R5: assert property (@(posedge clk) disable iff (rst)
    (duty_q > per_q) |=> pwm_o == $past(ctrl_q.idle));

  // R6: disabled without drain shows the idle level
  assert_off_level_R6: assert property (@(posedge clk) disable iff (rst)
    (!ctrl_q.oe && !drain_q) |=> pwm_o == $past(ctrl_q.idle));

  // R7: start and stop act on this channel
  assert_start_R7: assert property (@(posedge clk) disable iff (rst)
    start |=> run_o);
  assert_stop_R7: assert property (@(posedge clk) disable iff (rst)
    (stop && !start) |=> !run_o);

  // R8: a stopped counter holds
  assert_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (!run_q && !we_cnt) |=> $stable(cnt_q));

  // R9: abrupt shutdown leaves no drain
  assert_abrupt_R9: assert property (@(posedge clk) disable iff (rst)
    (we_ctrl && !ctrl_new.oe && ctrl_new.abrupt) |=> !drain_q);
endmodule

// File: rtl/pwm_timer_bank.sv
module pwm_timer_bank #(
  parameter int NCH  = 8,
  parameter int CW   = 16,
  parameter int CH_W = (NCH > 1) ? $clog2(NCH) : 1,
  parameter int AW   = CH_W + 3
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           wr_en,
  input  logic [AW-1:0]  wr_addr,
  input  logic [CW-1:0]  wr_data,
  input  logic [AW-1:0]  rd_addr,
  output logic [CW-1:0]  rd_data,
  input  logic [NCH-1:0] tick,
  output logic [NCH-1:0] pwm_out
);
  import pwm_bank_pkg::*;

  logic [NCH-1:0] we_cnt, we_duty, we_per, we_ctrl, start_set, stop_set;
  logic [NCH-1:0] run_v, pwm_v;
  logic [CW-1:0]  cnt_a  [NCH];
  logic [CW-1:0]  duty_a [NCH];
  logic [CW-1:0]  per_a  [NCH];
  chan_ctrl_t     ctrl_a [NCH];
  logic [CW-1:0]  rd_d, rd_q;
  logic [CH_W-1:0] rd_ch;

  pwm_regdec #(.NCH(NCH), .CW(CW), .CH_W(CH_W), .AW(AW)) u_dec (
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .we_cnt(we_cnt), .we_duty(we_duty), .we_per(we_per), .we_ctrl(we_ctrl),
    .start_set(start_set), .stop_set(stop_set)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    pwm_chan #(.CW(CW)) u_ch (
      .clk(clk), .rst(rst), .tick(tick[i]),
      .start(start_set[i]), .stop(stop_set[i]),
      .we_cnt(we_cnt[i]), .we_duty(we_duty[i]), .we_per(we_per[i]),
      .we_ctrl(we_ctrl[i]), .wdata(wr_data),
      .cnt_o(cnt_a[i]), .duty_o(duty_a[i]), .per_o(per_a[i]),
      .ctrl_o(ctrl_a[i]), .run_o(run_v[i]), .pwm_o(pwm_v[i])
    );
  end

  assign rd_ch = rd_addr[AW-2:2];

  always_comb begin
    rd_d = '0;
    if (rd_addr[AW-1]) begin
      rd_d = CW'(run_v);
    end else if (int'(rd_ch) < NCH) begin
      case (chan_field_e'(rd_addr[1:0]))
        FLD_COUNT:  rd_d = cnt_a[rd_ch];
        FLD_DUTY:   rd_d = duty_a[rd_ch];
        FLD_PERIOD: rd_d = per_a[rd_ch];
        default:    rd_d = CW'(ctrl_a[rd_ch]);
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rd_q <= '0;
    else     rd_q <= rd_d;
  end

  assign rd_data = rd_q;
  assign pwm_out = pwm_v;
endmodule

// File: tb/pwm_timer_bank_tb.sv
module pwm_timer_bank_tb;
  localparam int NCH = 8;
  localparam int CW  = 16;
  localparam int AW  = 6;
  localparam logic [AW-1:0] A_START = 6'b100000;
  localparam logic [AW-1:0] A_STOP  = 6'b100001;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0, rd_addr = '0;
  logic [CW-1:0] wr_data = '0;
  logic [CW-1:0] rd_data;
  logic [NCH-1:0] tick = '0, pwm_out;
  logic [NCH-1:0] tick_mask = '0;
  bit tick_rand = 0;

  int checks = 0, errors = 0;
  string cur_req = "R1";
  bit live = 0, done = 0;

  always #10 clk = ~clk;

  pwm_timer_bank #(.NCH(NCH), .CW(CW)) u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .tick(tick), .pwm_out(pwm_out)
  );

  function automatic logic [AW-1:0] ca(int ch, int f);
    return {1'b0, 3'(ch), 2'(f)};
  endfunction

  // behavioural reference model
  int m_cnt[NCH], m_duty[NCH], m_per[NCH];
  bit m_oe[NCH], m_idle[NCH], m_abr[NCH], m_run[NCH], m_drain[NCH];
  logic [NCH-1:0] e_pwm = '0;
  logic [CW-1:0] e_rd = '0;

  always @(posedge clk) begin
    if (rst) begin
      for (int c = 0; c < NCH; c++) begin
        m_cnt[c] = 0; m_duty[c] = 65535; m_per[c] = 65535;
        m_oe[c] = 0; m_idle[c] = 0; m_abr[c] = 0; m_run[c] = 0; m_drain[c] = 0;
      end
      e_pwm = '0; e_rd = '0;
    end else begin
      bit pe[NCH];
      for (int c = 0; c < NCH; c++) begin
        bit ph;
        ph = (m_cnt[c] >= m_duty[c]) && (m_duty[c] <= m_per[c]);
        e_pwm[c] = (m_oe[c] || m_drain[c]) ? (m_idle[c] ^ ph) : m_idle[c];
      end
      if (rd_addr[AW-1]) begin
        e_rd = '0;
        for (int c = 0; c < NCH; c++) e_rd[c] = m_run[c];
      end else begin
        int c;
        c = int'(rd_addr[4:2]);
        case (rd_addr[1:0])
          2'd0: e_rd = CW'(m_cnt[c]);
          2'd1: e_rd = CW'(m_duty[c]);
          2'd2: e_rd = CW'(m_per[c]);
          default: e_rd = CW'({m_abr[c], m_idle[c], m_oe[c]});
        endcase
      end
      for (int c = 0; c < NCH; c++) begin
        pe[c] = m_run[c] && tick[c] && (m_cnt[c] == m_per[c]);
        if (m_run[c] && tick[c]) m_cnt[c] = pe[c] ? 0 : (m_cnt[c] + 1) % 65536;
        if (pe[c]) m_drain[c] = 0;
      end
      if (wr_en) begin
        if (wr_addr[AW-1]) begin
          for (int c = 0; c < NCH; c++)
            if (wr_data[c]) m_run[c] = !wr_addr[0];
        end else begin
          int c;
          c = int'(wr_addr[4:2]);
          case (wr_addr[1:0])
            2'd0: m_cnt[c] = int'(wr_data);
            2'd1: m_duty[c] = int'(wr_data);
            2'd2: m_per[c] = int'(wr_data);
            default: begin
              if (wr_data[0] || wr_data[2]) m_drain[c] = 0;
              else if (m_oe[c] && m_run[c] && !pe[c]) m_drain[c] = 1;
              m_oe[c] = wr_data[0]; m_idle[c] = wr_data[1]; m_abr[c] = wr_data[2];
            end
          endcase
        end
      end
    end
  end

  // every-cycle comparison against the model
  always @(negedge clk) begin
    if (live && !done) begin
      checks++;
      if (pwm_out !== e_pwm) begin
        errors++;
        $display("FAIL %s pwm_out got %h expected %h at %0t", cur_req, pwm_out, e_pwm, $time);
      end
      checks++;
      if (rd_data !== e_rd) begin
        errors++;
        $display("FAIL R10 rd_data got %h expected %h at %0t", rd_data, e_rd, $time);
      end
    end
    tick <= tick_mask & (tick_rand ? NCH'($urandom) : '1);
  end

  task automatic chk(string r, int got, int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s got %0h expected %0h", r, got, exp);
    end
  endtask

  task automatic wr(logic [AW-1:0] a, logic [CW-1:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(logic [AW-1:0] a, output int v);
    @(negedge clk);
    rd_addr = a;
    @(negedge clk);
    v = int'(rd_data);
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    cyc(200000 - 10);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int v, ones;
    cyc(3);
    rst = 1'b0;
    live = 1;
    // R1 reset state
    cur_req = "R1";
    chk("R1 pwm_out", int'(pwm_out), 0);
    rd(ca(0, 1), v); chk("R1 duty ch0", v, 16'hFFFF);
    rd(ca(7, 2), v); chk("R1 period ch7", v, 16'hFFFF);
    rd(ca(3, 0), v); chk("R1 counter ch3", v, 0);
    rd(ca(5, 3), v); chk("R1 control ch5", v, 0);
    rd(A_START, v);  chk("R1 run mask", v, 0);

    // R3/R4/R10: ch2 duty 3 period 7 idle 0
    cur_req = "R3";
    tick_mask = '1;
    wr(ca(2, 1), 3); wr(ca(2, 2), 7); wr(ca(2, 3), 3'b001);
    rd(ca(2, 1), v); chk("R10 duty readback", v, 3);
    wr(A_START, 16'h0004);
    rd(A_START, v); chk("R7 start only ch2", v, 16'h0004);
    cyc(5);
    ones = 0;
    for (int k = 0; k < 16; k++) begin @(negedge clk); ones += pwm_out[2]; end
    chk("R3 ch2 high cycles per 16", ones, 10);
    cur_req = "R4";
    cyc(20);

    // R5: duty above period, idle 1
    cur_req = "R5";
    wr(ca(3, 1), 9); wr(ca(3, 2), 5); wr(ca(3, 3), 3'b011);
    wr(A_START, 16'h0008);
    cyc(2);
    ones = 0;
    for (int k = 0; k < 20; k++) begin @(negedge clk); ones += pwm_out[3]; end
    chk("R5 ch3 stays idle", ones, 20);

    // R4: duty 0 inverts from the start of each period
    cur_req = "R4";
    wr(ca(4, 1), 0); wr(ca(4, 2), 4); wr(ca(4, 3), 3'b011);
    wr(A_START, 16'h0010);
    cyc(30);

    // R6: disabled running channel holds idle 1
    cur_req = "R6";
    wr(ca(1, 1), 1); wr(ca(1, 2), 3); wr(ca(1, 3), 3'b010);
    wr(A_START, 16'h0002);
    cyc(2);
    ones = 0;
    for (int k = 0; k < 12; k++) begin @(negedge clk); ones += pwm_out[1]; end
    chk("R6 ch1 disabled idle", ones, 12);

    // R8: stop ch2 and check that it holds
    cur_req = "R8";
    wr(A_STOP, 16'h0004);
    rd(A_STOP, v); chk("R7 stop only ch2", v, 16'h001A);
    rd(ca(2, 0), v);
    begin
      int v2, p0;
      p0 = int'(pwm_out[2]);
      cyc(10);
      rd(ca(2, 0), v2); chk("R8 counter holds", v2, v);
      chk("R8 pwm holds", int'(pwm_out[2]), p0);
    end

    // R2: counter write while running
    cur_req = "R2";
    wr(ca(4, 0), 2);
    cyc(6);

    // R9: non-abrupt on ch5, abrupt on ch6, sparse ticks
    cur_req = "R9";
    tick_rand = 1;
    wr(ca(5, 1), 2); wr(ca(5, 2), 9); wr(ca(5, 3), 3'b001);
    wr(ca(6, 1), 2); wr(ca(6, 2), 9); wr(ca(6, 3), 3'b101);
    wr(A_START, 16'h0060);
    cyc(13);
    wr(ca(5, 3), 3'b000);
    wr(ca(6, 3), 3'b100);
    cyc(1);
    chk("R9 abrupt ch6 idle", int'(pwm_out[6]), 0);
    cyc(40);
    chk("R9 drained ch5 idle", int'(pwm_out[5]), 0);

    // mixed random traffic compared against the model
    cur_req = "R3";
    for (int c = 0; c < NCH; c++) begin
      wr(ca(c, 0), 0);
      wr(ca(c, 1), CW'($urandom_range(0, 12)));
      wr(ca(c, 2), CW'($urandom_range(0, 10)));
      wr(ca(c, 3), CW'($urandom_range(0, 7)));
    end
    wr(A_START, 16'h00FF);
    for (int k = 0; k < 300; k++) begin
      int c;
      c = $urandom_range(0, NCH - 1);
      case ($urandom_range(0, 5))
        0: wr(ca(c, 3), CW'($urandom_range(0, 7)));
        1: wr(ca(c, 1), CW'($urandom_range(0, 12)));
        2: wr(A_STOP, CW'(1 << c));
        3: wr(A_START, CW'(1 << c));
        default: cyc($urandom_range(1, 8));
      endcase
      rd_addr = ca($urandom_range(0, NCH - 1), $urandom_range(0, 3));
    end
    cyc(4);
    finish_run();
  end
endmodule